// File: doc/BRIEF.md
# Dual-Load Atomicity Monitor

This block performs one paired load: it fetches two independent memory operands, which need not sit next to each other, and reports whether the pair was seen as a single atomic snapshot. Each operand has its own size and must be naturally aligned to that size. The block reads the two containing words one after the other over a simple request/response memory port. It returns the extracted values for an even/odd destination register pair, with the first operand going to the even register.

While the two reads are in flight, the block watches two store-observation streams. One stream carries stores from other processors and the other carries stores from I/O agents. A store that really lands on the word of either operand inside the observation window marks the pair as torn. A store that merely could have landed does not. The condition code then reads 3 instead of 0, and both values are still returned. A misaligned operand raises a specification error instead, and no read is issued. The block handles one request at a time and never retries on its own. Any retry loop belongs to the requester.

States: IDLE accepts a request. It moves to FAULT when an operand is misaligned and to RD0_REQ otherwise. RD0_REQ holds the first read until it is accepted and then moves to RD0_WAIT. RD0_WAIT moves to RD1_REQ when the first response arrives. RD1_REQ moves to RD1_WAIT when the second read is accepted. RD1_WAIT moves to DONE on the second response. DONE and FAULT each last one cycle and then return to IDLE.

Top module: `pairload_monitor`

## Requirements
- R1: After reset, req_ready is 1 and done, spec_err, mem_req_valid and cc are all 0.
- R2: Size code s selects an operand of 1<<s bytes (0=1, 1=2, 2=4, 3=8). An operand is misaligned when its byte address is not a multiple of 1<<s. If either operand is misaligned, done and spec_err are both 1 in the cycle after acceptance, and no memory read is issued for that request.
- R3: An aligned request issues exactly two reads. The first read goes to the word-aligned address of the even operand (low three address bits zero) and the second to that of the odd operand. The second read is issued only after the first response. A read request stays asserted with a stable address while mem_req_ready is low.
- R4: Each result consists of the 1<<s bytes that start at the operand's byte offset within its 8-byte word. Bytes are little-endian, so the byte at that offset lands in bits 7:0. The result is zero-extended to 64 bits. The first operand goes to res_even and the second to res_odd.
- R5: done rises one cycle after the second response. With no matching foreign store inside the window, cc is 0.
- R6: A processor store (cpu_st_valid) whose word index equals the word index of either operand inside the window makes cc 3.
- R7: An I/O store (io_st_valid) that matches either operand's word inside the window also makes cc 3.
- R8: Matching compares the word index only (byte address shifted right by 3). A store to any other word has no effect on cc.
- R9: The window includes the cycle in which the first read is accepted and the cycle in which the second response arrives. It excludes the acceptance cycle of the request, any cycle in which the first read is still waiting for mem_req_ready, and the done cycle.
- R10: req_ready is low from acceptance until the block returns to idle, and done lasts one cycle. A req_valid presented while busy is ignored.
- R11: When cc is 3, both loaded values are still returned. The results hold until the next request is accepted.
- R12: After done, no further memory read is issued until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Paired-load request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr_even | input | ADDR_W | Byte address of the first operand |
| req_size_even | input | 2 | Size code of the first operand |
| req_addr_odd | input | ADDR_W | Byte address of the second operand |
| req_size_odd | input | 2 | Size code of the second operand |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8*WORD_BYTES | Returned word |
| cpu_st_valid | input | 1 | Processor store observed |
| cpu_st_word | input | ADDR_W-3 | Word index of the processor store |
| io_st_valid | input | 1 | I/O agent store observed |
| io_st_word | input | ADDR_W-3 | Word index of the I/O store |
| done | output | 1 | Result valid for one cycle |
| spec_err | output | 1 | Misaligned operand (with done) |
| cc | output | 2 | 0 atomic, 3 torn |
| res_even | output | 8*WORD_BYTES | First operand value |
| res_odd | output | 8*WORD_BYTES | Second operand value |

## Verification
The bench builds the block with its defaults: a 16-bit byte address and 8-byte words. With these values, all four operand sizes, every byte offset and both misalignment cases fit inside a small address space that the bench models as computed word contents. The memory model answers one cycle after accepting a read and can hold its ready low for a chosen number of cycles. Together these let stores be placed on each cycle edge of the window, including the stalled first read.

// File: rtl/pairload_pkg.sv
package pairload_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0_REQ,
        ST_RD0_WAIT,
        ST_RD1_REQ,
        ST_RD1_WAIT,
        ST_DONE,
        ST_FAULT
    } pl_state_e;

    localparam int SIZE_W = 2;
    localparam int NUM_SRC = 2;

    localparam logic [1:0] CC_ATOMIC = 2'd0;
    localparam logic [1:0] CC_TORN   = 2'd3;

endpackage

// File: rtl/pairload_align_chk.sv
module pairload_align_chk #(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0]                 off,
    input  logic [pairload_pkg::SIZE_W-1:0]  size,
    output logic                             misaligned
);
    logic [OFF_W-1:0] low_mask;
    logic             too_big;

    always_comb begin
        for (int i = 0; i < OFF_W; i++) begin
            low_mask[i] = (i < int'(size));
        end
        too_big    = (int'(size) > OFF_W);
        misaligned = (|(off & low_mask)) || too_big;
    end
endmodule

// File: rtl/pairload_lane_extract.sv
module pairload_lane_extract #(
    parameter int WORD_BYTES = 8,
    localparam int DATA_W = 8 * WORD_BYTES,
    localparam int OFF_W  = $clog2(WORD_BYTES)
) (
    input  logic [DATA_W-1:0]                word,
    input  logic [OFF_W-1:0]                 off,
    input  logic [pairload_pkg::SIZE_W-1:0]  size,
    output logic [DATA_W-1:0]                value
);
    logic [DATA_W-1:0] shifted;
    int unsigned       nbytes;

    always_comb begin
        shifted = word >> {off, 3'b000};
        nbytes  = 32'd1 << size;
        for (int b = 0; b < WORD_BYTES; b++) begin
            value[b*8 +: 8] = (b < int'(nbytes)) ? shifted[b*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/pairload_snoop_match.sv
module pairload_snoop_match #(
    parameter int WIDX_W = 13
) (
    input  logic              st_valid,
    input  logic [WIDX_W-1:0] st_word,
    input  logic [WIDX_W-1:0] word_a,
    input  logic [WIDX_W-1:0] word_b,
    output logic              hit
);
    always_comb begin
        hit = st_valid && ((st_word == word_a) || (st_word == word_b));
    end
endmodule

// File: rtl/pairload_monitor.sv
module pairload_monitor #(
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 8,
    localparam int DATA_W = 8 * WORD_BYTES,
    localparam int OFF_W  = $clog2(WORD_BYTES),
    localparam int WIDX_W = ADDR_W - OFF_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [ADDR_W-1:0]                   req_addr_even,
    input  logic [pairload_pkg::SIZE_W-1:0]     req_size_even,
    input  logic [ADDR_W-1:0]                   req_addr_odd,
    input  logic [pairload_pkg::SIZE_W-1:0]     req_size_odd,
    output logic                                mem_req_valid,
    input  logic                                mem_req_ready,
    output logic [ADDR_W-1:0]                   mem_req_addr,
    input  logic                                mem_rsp_valid,
    input  logic [DATA_W-1:0]                   mem_rsp_data,
    input  logic                                cpu_st_valid,
    input  logic [WIDX_W-1:0]                   cpu_st_word,
    input  logic                                io_st_valid,
    input  logic [WIDX_W-1:0]                   io_st_word,
    output logic                                done,
    output logic                                spec_err,
    output logic [1:0]                          cc,
    output logic [DATA_W-1:0]                   res_even,
    output logic [DATA_W-1:0]                   res_odd
);
    import pairload_pkg::*;

    pl_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr0_q, addr1_q;
    logic [SIZE_W-1:0] size0_q, size1_q;
    logic              torn_q;
    logic [DATA_W-1:0] res0_q, res1_q;

    logic              accept;
    logic              mis0, mis1;
    logic              in_window;
    logic [DATA_W-1:0] lane0, lane1;

    logic [NUM_SRC-1:0] src_valid;
    logic [WIDX_W-1:0]  src_word [NUM_SRC];
    logic [NUM_SRC-1:0] src_hit;

    // Alignment is judged on the request as presented.
    pairload_align_chk #(.OFF_W(OFF_W)) u_align_even (
        .off        (req_addr_even[OFF_W-1:0]),
        .size       (req_size_even),
        .misaligned (mis0)
    );

    pairload_align_chk #(.OFF_W(OFF_W)) u_align_odd (
        .off        (req_addr_odd[OFF_W-1:0]),
        .size       (req_size_odd),
        .misaligned (mis1)
    );

    // Lane selection from the returned word for each operand.
    pairload_lane_extract #(.WORD_BYTES(WORD_BYTES)) u_lane_even (
        .word  (mem_rsp_data),
        .off   (addr0_q[OFF_W-1:0]),
        .size  (size0_q),
        .value (lane0)
    );

    pairload_lane_extract #(.WORD_BYTES(WORD_BYTES)) u_lane_odd (
        .word  (mem_rsp_data),
        .off   (addr1_q[OFF_W-1:0]),
        .size  (size1_q),
        .value (lane1)
    );

    // One matcher per store-observation source.
    assign src_valid   = {io_st_valid, cpu_st_valid};
    assign src_word[0] = cpu_st_word;
    assign src_word[1] = io_st_word;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_snoop
        pairload_snoop_match #(.WIDX_W(WIDX_W)) u_match (
            .st_valid (src_valid[s]),
            .st_word  (src_word[s]),
            .word_a   (addr0_q[ADDR_W-1:OFF_W]),
            .word_b   (addr1_q[ADDR_W-1:OFF_W]),
            .hit      (src_hit[s])
        );
    end

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        in_window = 1'b0;
        unique case (state_q)
            ST_RD0_REQ:  in_window = mem_req_ready;
            ST_RD0_WAIT: in_window = 1'b1;
            ST_RD1_REQ:  in_window = 1'b1;
            ST_RD1_WAIT: in_window = 1'b1;
            default:     in_window = 1'b0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (mis0 || mis1) ? ST_FAULT : ST_RD0_REQ;
                end
            end
            ST_RD0_REQ: begin
                if (mem_req_ready) state_d = ST_RD0_WAIT;
            end
            ST_RD0_WAIT: begin
                if (mem_rsp_valid) state_d = ST_RD1_REQ;
            end
            ST_RD1_REQ: begin
                if (mem_req_ready) state_d = ST_RD1_WAIT;
            end
            ST_RD1_WAIT: begin
                if (mem_rsp_valid) state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture, torn flag and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr0_q <= '0;
            addr1_q <= '0;
            size0_q <= '0;
            size1_q <= '0;
            torn_q  <= 1'b0;
            res0_q  <= '0;
            res1_q  <= '0;
        end else begin
            if (accept) begin
                addr0_q <= req_addr_even;
                addr1_q <= req_addr_odd;
                size0_q <= req_size_even;
                size1_q <= req_size_odd;
                torn_q  <= 1'b0;
                res0_q  <= '0;
                res1_q  <= '0;
            end else begin
                if (in_window && (|src_hit)) torn_q <= 1'b1;
                if ((state_q == ST_RD0_WAIT) && mem_rsp_valid) res0_q <= lane0;
                if ((state_q == ST_RD1_WAIT) && mem_rsp_valid) res1_q <= lane1;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = {addr0_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        done          = 1'b0;
        spec_err      = 1'b0;
        cc            = CC_ATOMIC;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_RD0_REQ:  mem_req_valid = 1'b1;
            ST_RD0_WAIT: ;
            ST_RD1_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {addr1_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end
            ST_RD1_WAIT: ;
            ST_DONE: begin
                done = 1'b1;
                cc   = torn_q ? CC_TORN : CC_ATOMIC;
            end
            ST_FAULT: begin
                done     = 1'b1;
                spec_err = 1'b1;
            end
            default: ;
        endcase
        res_even = res0_q;
        res_odd  = res1_q;
    end
endmodule

// File: rtl/pairload_monitor_chk.sv
module pairload_monitor_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic              spec_err,
    input logic [1:0]        cc
);
    logic [1:0] hs_cnt;
    logic [1:0] rsp_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_cnt  <= '0;
            rsp_cnt <= '0;
        end else if (req_valid && req_ready) begin
            hs_cnt  <= '0;
            rsp_cnt <= '0;
        end else begin
            if (mem_req_valid && mem_req_ready && hs_cnt != 2'd3) hs_cnt <= hs_cnt + 2'd1;
            if (mem_rsp_valid && rsp_cnt != 2'd3) rsp_cnt <= rsp_cnt + 2'd1;
        end
    end

    AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> hs_cnt == 2'd0); // R2
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> done); // R2
    AST_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !spec_err) |-> (hs_cnt == 2'd2 && rsp_cnt == 2'd2)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R3
    AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !spec_err) |-> (cc == 2'd0 || cc == 2'd3)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> hs_cnt < 2'd2); // R12
endmodule

bind pairload_monitor pairload_monitor_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .spec_err      (spec_err),
    .cc            (cc)
);

// File: tb/pairload_monitor_test.sv
`timescale 1ns/1ps
module pairload_monitor_test;

    localparam int ADDR_W = 16;
    localparam int WB     = 8;
    localparam int DW     = 8 * WB;
    localparam int WIDX_W = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr_even = '0;
    logic [1:0]        req_size_even = '0;
    logic [ADDR_W-1:0] req_addr_odd = '0;
    logic [1:0]        req_size_odd = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DW-1:0]     mem_rsp_data = '0;
    logic              cpu_st_valid = 1'b0;
    logic [WIDX_W-1:0] cpu_st_word = '0;
    logic              io_st_valid = 1'b0;
    logic [WIDX_W-1:0] io_st_word = '0;
    logic              done;
    logic              spec_err;
    logic [1:0]        cc;
    logic [DW-1:0]     res_even;
    logic [DW-1:0]     res_odd;

    always #4 clk = ~clk;

    pairload_monitor #(.ADDR_W(ADDR_W), .WORD_BYTES(WB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr_even(req_addr_even), .req_size_even(req_size_even),
        .req_addr_odd(req_addr_odd), .req_size_odd(req_size_odd),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cpu_st_valid(cpu_st_valid),
        .cpu_st_word(cpu_st_word), .io_st_valid(io_st_valid), .io_st_word(io_st_word),
        .done(done), .spec_err(spec_err), .cc(cc), .res_even(res_even), .res_odd(res_odd)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Word contents of the modelled memory, computed from the word index.
    function automatic logic [DW-1:0] mem_word(input logic [15:0] w);
        return {w, ~w, w ^ 16'h5A5A, w + 16'h1111};
    endfunction

    function automatic logic [DW-1:0] exp_val(input logic [ADDR_W-1:0] a, input logic [1:0] s);
        logic [DW-1:0] wd;
        logic [DW-1:0] mask;
        int nb;
        wd = mem_word({3'b000, a[ADDR_W-1:3]}) >> (8 * int'(a[2:0]));
        nb = 1 << s;
        mask = (nb == 8) ? {DW{1'b1}} : ((64'd1 << (8 * nb)) - 64'd1);
        return wd & mask;
    endfunction

    // Memory model: optional ready stall, response one cycle after acceptance.
    int                stall_left = 0;
    int                hs_cnt = 0;
    logic [ADDR_W-1:0] hs_addr [4];
    bit                pend = 0;
    logic [ADDR_W-1:0] pend_addr = '0;

    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = pend;
            mem_rsp_data  = pend ? mem_word({3'b000, pend_addr[ADDR_W-1:3]}) : '0;
            pend = 0;
            if (mem_req_valid && stall_left > 0) begin
                mem_req_ready = 1'b0;
                stall_left--;
            end else begin
                mem_req_ready = 1'b1;
            end
            if (mem_req_valid && mem_req_ready) begin
                pend = 1;
                pend_addr = mem_req_addr;
                if (hs_cnt < 4) hs_addr[hs_cnt] = mem_req_addr;
                hs_cnt++;
            end
        end
    end

    // Captured outcome of the last operation.
    bit            got;
    logic          cap_err;
    logic [1:0]    cap_cc;
    logic [DW-1:0] cap_even, cap_odd;

    task automatic drive_store(input logic [1:0] src, input logic [WIDX_W-1:0] w);
        cpu_st_valid = (src == 2'd1);
        io_st_valid  = (src == 2'd2);
        cpu_st_word  = w;
        io_st_word   = w;
    endtask

    task automatic do_op(input logic [ADDR_W-1:0] a0, input logic [1:0] s0,
                         input logic [ADDR_W-1:0] a1, input logic [1:0] s1,
                         input logic [1:0] src, input logic [WIDX_W-1:0] sw,
                         input int st_cyc, input int stall, input bit intrude);
        int k;
        @(negedge clk);
        stall_left = stall;
        hs_cnt = 0;
        req_addr_even = a0; req_size_even = s0;
        req_addr_odd  = a1; req_size_odd  = s1;
        req_valid = 1'b1;
        drive_store(2'd0, '0);
        if (st_cyc == 0) drive_store(src, sw);
        k = 0;
        got = 0;
        while (!got && k < 40) begin
            @(negedge clk);
            k++;
            req_valid = 1'b0;
            drive_store(2'd0, '0);
            if (k == st_cyc) drive_store(src, sw);
            if (intrude && k == 2) begin
                req_valid = 1'b1;
                req_addr_even = 16'h0013; req_size_even = 2'd3;
                req_addr_odd  = 16'h0400; req_size_odd  = 2'd3;
            end
            if (done) begin
                got = 1;
                cap_err = spec_err; cap_cc = cc;
                cap_even = res_even; cap_odd = res_odd;
            end
        end
        req_valid = 1'b0;
        drive_store(2'd0, '0);
        if (!got) begin
            n_checks++; n_fail++;
            $display("FAIL R5: done not seen, actual 0 expected 1");
        end
    endtask

    typedef struct packed {
        logic [15:0] a0;
        logic [1:0]  s0;
        logic [15:0] a1;
        logic [1:0]  s1;
        logic [1:0]  src;     // 0 none, 1 processor, 2 I/O
        logic [12:0] sw;      // store word index
        logic [3:0]  st_cyc;  // cycle after request drive
        logic [1:0]  stall;
        logic        exp_err;
        logic [1:0]  exp_cc;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 2'd3, 16'h0108, 2'd3, 2'd0, 13'h000, 4'd0, 2'd0, 1'b0, 2'd0, 4'd4}, // R4 full words
        '{16'h0012, 2'd1, 16'h0207, 2'd0, 2'd0, 13'h000, 4'd0, 2'd0, 1'b0, 2'd0, 4'd4}, // R4 sub-word lanes
        '{16'h0020, 2'd2, 16'h0304, 2'd2, 2'd1, 13'h004, 4'd2, 2'd0, 1'b0, 2'd3, 4'd6}, // R6 processor store
        '{16'h0020, 2'd2, 16'h0304, 2'd2, 2'd2, 13'h060, 4'd3, 2'd0, 1'b0, 2'd3, 4'd7}, // R7 I/O store
        '{16'h0040, 2'd3, 16'h0048, 2'd3, 2'd1, 13'h00A, 4'd2, 2'd0, 1'b0, 2'd0, 4'd8}, // R8 other word
        '{16'h0040, 2'd3, 16'h0048, 2'd3, 2'd1, 13'h008, 4'd1, 2'd0, 1'b0, 2'd3, 4'd9}, // R9 first read accepted
        '{16'h0040, 2'd3, 16'h0048, 2'd3, 2'd2, 13'h009, 4'd4, 2'd0, 1'b0, 2'd3, 4'd9}, // R9 second response
        '{16'h0040, 2'd3, 16'h0048, 2'd3, 2'd1, 13'h008, 4'd5, 2'd0, 1'b0, 2'd0, 4'd9}, // R9 done cycle
        '{16'h0040, 2'd3, 16'h0048, 2'd3, 2'd1, 13'h008, 4'd1, 2'd1, 1'b0, 2'd0, 4'd9}, // R9 stalled read
        '{16'h0040, 2'd3, 16'h0048, 2'd3, 2'd1, 13'h008, 4'd0, 2'd0, 1'b0, 2'd0, 4'd9}, // R9 accept cycle
        '{16'h0012, 2'd2, 16'h0100, 2'd3, 2'd0, 13'h000, 4'd0, 2'd0, 1'b1, 2'd0, 4'd2}, // R2 even misaligned
        '{16'h0040, 2'd3, 16'h0044, 2'd3, 2'd0, 13'h000, 4'd0, 2'd0, 1'b1, 2'd0, 4'd2}, // R2 odd misaligned
        '{16'h0101, 2'd0, 16'h0036, 2'd1, 2'd0, 13'h000, 4'd0, 2'd0, 1'b0, 2'd0, 4'd5}  // R5 quiet
    };

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 req_ready", {63'd0, req_ready}, 64'd1);
        check(done == 1'b0 && spec_err == 1'b0, "R1 done/spec_err", {62'd0, done, spec_err}, 64'd0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
        check(cc == 2'd0, "R1 cc", {62'd0, cc}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = $sformatf("R%0d vec %0d", v.tag, i);
            do_op(v.a0, v.s0, v.a1, v.s1, v.src, v.sw, int'(v.st_cyc), int'(v.stall), 1'b0);
            check(cap_err == v.exp_err, {t, " spec_err"}, {63'd0, cap_err}, {63'd0, v.exp_err});
            if (v.exp_err) begin
                check(hs_cnt == 0, {t, " reads issued"}, 64'(hs_cnt), 64'd0);
            end else begin
                check(cap_cc == v.exp_cc, {t, " cc"}, {62'd0, cap_cc}, {62'd0, v.exp_cc});
                check(cap_even == exp_val(v.a0, v.s0), {t, " R4/R11 res_even"}, cap_even, exp_val(v.a0, v.s0));
                check(cap_odd == exp_val(v.a1, v.s1), {t, " R4/R11 res_odd"}, cap_odd, exp_val(v.a1, v.s1));
                check(hs_cnt == 2, {t, " R3 read count"}, 64'(hs_cnt), 64'd2);
                check(hs_addr[0] == {v.a0[15:3], 3'b000}, {t, " R3 first read"},
                      64'(hs_addr[0]), 64'({v.a0[15:3], 3'b000}));
                check(hs_addr[1] == {v.a1[15:3], 3'b000}, {t, " R3 second read"},
                      64'(hs_addr[1]), 64'({v.a1[15:3], 3'b000}));
            end
        end

        // R10: a request presented while busy is ignored
        do_op(16'h0080, 2'd3, 16'h0208, 2'd2, 2'd0, '0, 0, 0, 1'b1);
        check(cap_err == 1'b0, "R10 busy request ignored", {63'd0, cap_err}, 64'd0);
        check(cap_even == exp_val(16'h0080, 2'd3), "R10 res_even", cap_even, exp_val(16'h0080, 2'd3));
        check(hs_cnt == 2, "R10 read count", 64'(hs_cnt), 64'd2);
        @(negedge clk);
        check(req_ready == 1'b1 && done == 1'b0, "R10 back to idle", {62'd0, req_ready, done}, 64'd2);

        // R12 and R11: torn result, no retry, results held
        do_op(16'h0090, 2'd3, 16'h0098, 2'd3, 2'd1, 13'h012, 3, 0, 1'b0);
        check(cap_cc == 2'd3, "R11 torn cc", {62'd0, cap_cc}, 64'd3);
        check(cap_odd == exp_val(16'h0098, 2'd3), "R11 torn res_odd", cap_odd, exp_val(16'h0098, 2'd3));
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            check(mem_req_valid == 1'b0 && done == 1'b0, "R12 no retry",
                  {62'd0, mem_req_valid, done}, 64'd0);
        end
        check(hs_cnt == 2, "R12 read count", 64'(hs_cnt), 64'd2);
        check(res_even == exp_val(16'h0090, 2'd3), "R11 res_even held", res_even, exp_val(16'h0090, 2'd3));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule